// File: doc/BRIEF.md
# Interval Timer Counter Channel

This block holds two 16-bit down-counting interval timer channels, known to software as channel 0 and channel 2. They share one byte-wide control port and one byte-wide data port. A tick enable, nominally at 1193180 Hz, moves every running channel one count lower. A control byte picks a channel and sets its counting mode. The same byte can also freeze a snapshot of that channel's count for reading.

A count is loaded as two byte writes, low byte first. A single staging flag holds the half-written value, and both data ports share that flag. In one-shot mode (mode 0) a channel stops at zero and raises bit 5 of its status byte. In every other mode it keeps counting and wraps around. Reads return the count a byte at a time, low byte first, taken either from the frozen snapshot or from the live counter.

Top module: `itc_timer_pair`

## Requirements
- R1: After reset both channels hold count 0 and status 0 in mode 0, they stay idle (ticks do not change the count) until a count is loaded, and cfg_err is 0.
- R2: A data write while nothing is staged stores the byte as the low byte. The next data write, to either channel's port, loads {byte, staged low byte} into the channel that port addresses, clears that channel's status byte and starts it counting. The other channel is untouched.
- R3: A running channel decrements by exactly one in each cycle with tick_en high, and holds its count when tick_en is low.
- R4: In mode 0 (control bits [3:1] = 000), when a running count reaches 0 the status byte becomes 8'h20 (bit 5). The count then stays at 0 on later ticks until the next load.
- R5: In any mode other than 0 the count keeps decrementing past 0, wrapping to 16'hFFFF, and the status byte stays 0.
- R6: Control bits [7:6] select the channel (00 = channel 0, 10 = channel 2). Bits [5:4] = 11 only sets the mode. Bits [5:4] = 00 sets the mode and issues a count-latch command. Bits [3:1] give the mode. Bit 0 must be 0.
- R7: A control byte with select 01 or 11, access 01 or 10, or bit 0 set raises cfg_err for exactly one cycle, in the cycle after the write. It changes no channel state.
- R8: A latch command snapshots the live count only when no snapshot is held. While one is held, reads return its low byte and then its high byte, and the high-byte read releases it.
- R9: With no snapshot held, the first read after reset or after a latch command returns the live low byte, and every later read returns the live high byte.
- R10: rd_data takes the selected channel's byte in the cycle after dat_rd and keeps its value in cycles without dat_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Count tick enable (1193180 Hz rate) |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_data | input | 8 | Control byte |
| dat_wr | input | 1 | Data byte write strobe |
| dat_rd | input | 1 | Data byte read strobe |
| dat_sel | input | 1 | Data port select: 0 = channel 0, 1 = channel 2 |
| dat_wdata | input | 8 | Data byte to write |
| rd_data | output | 8 | Registered read byte |
| chan_status | output | 16 | Status bytes: [7:0] channel 0, [15:8] channel 2 |
| cfg_err | output | 1 | One-cycle pulse on an unsupported control byte |

## Verification
The bench goes after the byte pairing that crosses ports. A design that kept a staging flag per channel would leave channel 2 unloaded when its low byte went through channel 0's port. It also checks that a second latch command while a snapshot is held is ignored; a design that re-snapshots would return the later, smaller count. One-shot counts are checked at and after zero: an off-by-one stop or a missing halt shows up as a wrong status byte or a count of 16'hFFFF. Unsupported control bytes are sent to a running channel in mode 2, so a design that still applied the mode field would stop at zero with status 8'h20.

// File: rtl/itc_pkg.sv
package itc_pkg;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LOW   = 2'b01,
    ACC_HIGH  = 2'b10,
    ACC_PAIR  = 2'b11
  } acc_e;

  typedef struct packed {
    logic [1:0] sel;
    logic [1:0] acc;
    logic [2:0] mode;
    logic       bcd;
  } ctl_word_t;

  localparam logic [7:0] TC_STATUS = 8'h20;
  localparam logic [2:0] MODE_ONESHOT = 3'd0;

endpackage

// File: rtl/itc_ctl_dec.sv
module itc_ctl_dec #(
  parameter int unsigned NCH = 2,
  parameter logic [2*NCH-1:0] CH_CODES = 4'b10_00
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ctl_wr,
  input  logic [7:0]     ctl_data,
  output logic [NCH-1:0] mode_we,
  output logic [NCH-1:0] latch_req,
  output logic [2:0]     mode_val,
  output logic           cfg_err
);
  import itc_pkg::*;

  ctl_word_t      cw;
  logic [NCH-1:0] hit;
  logic           acc_ok;
  logic           sel_ok;
  logic           err_d;
  logic           err_q;

  assign cw       = ctl_word_t'(ctl_data);
  assign acc_ok   = (cw.acc == ACC_LATCH) || (cw.acc == ACC_PAIR);
  assign mode_val = cw.mode;

  for (genvar i = 0; i < NCH; i++) begin : g_hit
    assign hit[i]       = (cw.sel == CH_CODES[2*i +: 2]);
    assign mode_we[i]   = ctl_wr && acc_ok && !cw.bcd && hit[i];
    assign latch_req[i] = mode_we[i] && (cw.acc == ACC_LATCH);
  end

  assign sel_ok = |hit;

  always_comb begin
    err_d = ctl_wr && !(acc_ok && sel_ok && !cw.bcd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign cfg_err = err_q;

  a_r7_bad_select_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !sel_ok) |=> cfg_err);
  a_r7_bad_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !sel_ok) |-> (mode_we == '0));
  a_r6_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mode_we));
  a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_wr) |=> !cfg_err);

endmodule

// File: rtl/itc_stage.sv
module itc_stage #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [BYTE_W-1:0]   wdata,
  output logic                load,
  output logic [2*BYTE_W-1:0] load_val
);
  logic              pend_q, pend_d;
  logic [BYTE_W-1:0] lo_q, lo_d;

  always_comb begin
    pend_d = pend_q;
    lo_d   = lo_q;
    if (wr) begin
      if (pend_q) begin
        pend_d = 1'b0;
      end else begin
        pend_d = 1'b1;
        lo_d   = wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      lo_q   <= '0;
    end else begin
      pend_q <= pend_d;
      lo_q   <= lo_d;
    end
  end

  assign load     = wr && pend_q;
  assign load_val = {wdata, lo_q};

  a_r2_pair_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (pend_q != $past(pend_q)));
  a_r2_pair_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr) |=> $stable(pend_q) && $stable(lo_q));

endmodule

// File: rtl/itc_chan.sv
module itc_chan #(
  parameter int unsigned COUNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               load,
  input  logic [COUNT_W-1:0] load_val,
  input  logic               mode_we,
  input  logic [2:0]         mode_val,
  input  logic               latch_req,
  input  logic               rd,
  output logic [COUNT_W/2-1:0] rd_byte,
  output logic [7:0]         status
);
  import itc_pkg::*;

  localparam int unsigned BYTE_W = COUNT_W / 2;

  logic [COUNT_W-1:0] cnt_q, cnt_d;
  logic [COUNT_W-1:0] lat_q, lat_d;
  logic [7:0]         stat_q, stat_d;
  logic [2:0]         mode_q, mode_d;
  logic               run_q, run_d;
  logic               lat_on_q, lat_on_d;
  logic               msb_q, msb_d;
  logic [COUNT_W-1:0] src;

  always_comb begin
    cnt_d    = cnt_q;
    lat_d    = lat_q;
    stat_d   = stat_q;
    mode_d   = mode_q;
    run_d    = run_q;
    lat_on_d = lat_on_q;
    msb_d    = msb_q;

    if (mode_we) mode_d = mode_val;

    if (load) begin
      cnt_d  = load_val;
      stat_d = '0;
      run_d  = 1'b1;
    end else if (tick && run_q) begin
      cnt_d = cnt_q - 1'b1;
      if (mode_q == MODE_ONESHOT && cnt_q == COUNT_W'(1)) begin
        stat_d = TC_STATUS;
        run_d  = 1'b0;
      end
    end

    if (rd) begin
      if (!msb_q)        msb_d    = 1'b1;
      else if (lat_on_q) lat_on_d = 1'b0;
    end

    if (latch_req && !lat_on_q) begin
      lat_on_d = 1'b1;
      msb_d    = 1'b0;
      lat_d    = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      lat_q    <= '0;
      stat_q   <= '0;
      mode_q   <= MODE_ONESHOT;
      run_q    <= 1'b0;
      lat_on_q <= 1'b0;
      msb_q    <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      lat_q    <= lat_d;
      stat_q   <= stat_d;
      mode_q   <= mode_d;
      run_q    <= run_d;
      lat_on_q <= lat_on_d;
      msb_q    <= msb_d;
    end
  end

  assign src     = lat_on_q ? lat_q : cnt_q;
  assign rd_byte = msb_q ? src[COUNT_W-1:BYTE_W] : src[BYTE_W-1:0];
  assign status  = stat_q;

  a_r2_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)) && (stat_q == '0));
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run_q && !load) |=> (cnt_q == $past(cnt_q) - COUNT_W'(1)));
  a_r3_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt_q));
  a_r4_tc_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q == TC_STATUS && !load) |=> $stable(cnt_q) && (stat_q == TC_STATUS));
  a_r8_snapshot_held: assert property (@(posedge clk) disable iff (!rst_n)
    lat_on_q |=> $stable(lat_q));

endmodule

// File: rtl/itc_timer_pair.sv
module itc_timer_pair #(
  parameter int unsigned COUNT_W  = 16,
  parameter int unsigned NCH      = 2,
  parameter logic [2*NCH-1:0] CH_CODES = 4'b10_00,
  localparam int unsigned BYTE_W  = COUNT_W / 2,
  localparam int unsigned SEL_W   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              ctl_wr,
  input  logic [7:0]        ctl_data,
  input  logic              dat_wr,
  input  logic              dat_rd,
  input  logic [SEL_W-1:0]  dat_sel,
  input  logic [BYTE_W-1:0] dat_wdata,
  output logic [BYTE_W-1:0] rd_data,
  output logic [8*NCH-1:0]  chan_status,
  output logic              cfg_err
);

  logic [1:0]         rst_sync;
  logic               rst_int_n;
  logic [NCH-1:0]     mode_we, latch_req;
  logic [2:0]         mode_val;
  logic               st_load;
  logic [COUNT_W-1:0] st_val;
  logic [BYTE_W-1:0]  ch_byte [NCH];
  logic [BYTE_W-1:0]  rd_q, rd_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  itc_ctl_dec #(.NCH(NCH), .CH_CODES(CH_CODES)) u_dec (
    .clk(clk), .rst_n(rst_int_n), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
    .mode_we(mode_we), .latch_req(latch_req), .mode_val(mode_val),
    .cfg_err(cfg_err)
  );

  itc_stage #(.BYTE_W(BYTE_W)) u_stage (
    .clk(clk), .rst_n(rst_int_n), .wr(dat_wr), .wdata(dat_wdata),
    .load(st_load), .load_val(st_val)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [7:0] stat_i;
    itc_chan #(.COUNT_W(COUNT_W)) u_chan (
      .clk(clk), .rst_n(rst_int_n), .tick(tick_en),
      .load(st_load && (dat_sel == SEL_W'(i))), .load_val(st_val),
      .mode_we(mode_we[i]), .mode_val(mode_val), .latch_req(latch_req[i]),
      .rd(dat_rd && (dat_sel == SEL_W'(i))), .rd_byte(ch_byte[i]),
      .status(stat_i)
    );
    assign chan_status[8*i +: 8] = stat_i;
  end

  always_comb begin
    rd_d = rd_q;
    if (dat_rd) rd_d = ch_byte[dat_sel];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rd_q <= '0;
    else            rd_q <= rd_d;
  end

  assign rd_data = rd_q;

  a_r10_read_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!dat_rd) |=> $stable(rd_data));

endmodule

// File: tb/itc_timer_pair_tb_top.sv
`timescale 1ns/1ps
module itc_timer_pair_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_en, ctl_wr, dat_wr, dat_rd;
  logic [7:0] ctl_data, dat_wdata;
  logic [0:0] dat_sel;
  logic [7:0] rd_data;
  logic [15:0] chan_status;
  logic       cfg_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  itc_timer_pair dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ctl_wr(ctl_wr),
    .ctl_data(ctl_data), .dat_wr(dat_wr), .dat_rd(dat_rd), .dat_sel(dat_sel),
    .dat_wdata(dat_wdata), .rd_data(rd_data), .chan_status(chan_status),
    .cfg_err(cfg_err)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ctl(input logic [7:0] b);
    @(negedge clk); ctl_wr = 1'b1; ctl_data = b;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic dwr(input logic s, input logic [7:0] b);
    @(negedge clk); dat_wr = 1'b1; dat_sel = s; dat_wdata = b;
    @(negedge clk); dat_wr = 1'b0;
  endtask

  task automatic rd(input logic s, output logic [7:0] v);
    @(negedge clk); dat_rd = 1'b1; dat_sel = s;
    @(negedge clk); dat_rd = 1'b0; v = rd_data;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic rd_pair(input logic s, input string tag, input logic [15:0] exp);
    logic [7:0] lo, hi;
    rd(s, lo);
    rd(s, hi);
    chk(tag, {hi, lo}, exp);
  endtask

  task automatic t_reset();
    chk("R1 status after reset", chan_status, 16'h0000);
    chk("R1 cfg_err after reset", {15'd0, cfg_err}, 16'h0000);
    tick(3);
    ctl(8'h00);
    rd_pair(1'b0, "R1 idle count stays 0", 16'h0000);
  endtask

  task automatic t_unlatched();
    logic [7:0] v;
    ctl(8'h92);
    dwr(1'b1, 8'h34); dwr(1'b1, 8'h12);
    rd(1'b1, v); chk("R9 first live read is LSB", {8'h0, v}, 16'h0034);
    rd(1'b1, v); chk("R9 second live read is MSB", {8'h0, v}, 16'h0012);
    rd(1'b1, v); chk("R9 later live read stays MSB", {8'h0, v}, 16'h0012);
    @(negedge clk); @(negedge clk);
    chk("R10 rd_data holds without read", {8'h0, rd_data}, 16'h0012);
  endtask

  task automatic t_load_dec();
    ctl(8'h34);
    chk("R6 good control word no error", {15'd0, cfg_err}, 16'h0000);
    dwr(1'b0, 8'h10); dwr(1'b0, 8'h00);
    chk("R2 load clears status", chan_status, 16'h0000);
    tick(3);
    ctl(8'h04);
    rd_pair(1'b0, "R3 three ticks from 0x10", 16'h000D);
  endtask

  task automatic t_wrap();
    dwr(1'b0, 8'h01); dwr(1'b0, 8'h00);
    tick(2);
    ctl(8'h04);
    rd_pair(1'b0, "R5 periodic mode wraps", 16'hFFFF);
    chk("R5 periodic status stays 0", {8'h0, chan_status[7:0]}, 16'h0000);
  endtask

  task automatic t_oneshot();
    ctl(8'hB0);
    dwr(1'b1, 8'h03); dwr(1'b1, 8'h00);
    tick(2);
    chk("R4 status before zero", {8'h0, chan_status[15:8]}, 16'h0000);
    tick(1);
    chk("R4 status 0x20 at zero", {8'h0, chan_status[15:8]}, 16'h0020);
    tick(2);
    ctl(8'h80);
    rd_pair(1'b1, "R4 count held at zero", 16'h0000);
    dwr(1'b1, 8'h05); dwr(1'b1, 8'h00);
    chk("R2 reload clears status", {8'h0, chan_status[15:8]}, 16'h0000);
  endtask

  task automatic t_shared();
    dwr(1'b0, 8'h22); dwr(1'b1, 8'h11);
    ctl(8'h80);
    rd_pair(1'b1, "R2 cross-port pair loads channel 2", 16'h1122);
    ctl(8'h04);
    rd_pair(1'b0, "R2 channel 0 untouched", 16'hFFFA);
  endtask

  task automatic t_latch_hold();
    ctl(8'h04);
    tick(3);
    ctl(8'h04);
    rd_pair(1'b0, "R8 second latch ignored", 16'hFFFA);
    ctl(8'h04);
    rd_pair(1'b0, "R8 fresh latch after release", 16'hFFF7);
  endtask

  task automatic t_errors();
    ctl(8'h34);
    dwr(1'b0, 8'h01); dwr(1'b0, 8'h00);
    ctl(8'h10);
    chk("R7 bad access raises cfg_err", {15'd0, cfg_err}, 16'h0001);
    @(negedge clk);
    chk("R7 cfg_err lasts one cycle", {15'd0, cfg_err}, 16'h0000);
    ctl(8'h41);
    chk("R7 bad select raises cfg_err", {15'd0, cfg_err}, 16'h0001);
    ctl(8'h01);
    chk("R7 bcd bit raises cfg_err", {15'd0, cfg_err}, 16'h0001);
    tick(1);
    chk("R7 mode unchanged, no terminal status", {8'h0, chan_status[7:0]}, 16'h0000);
    ctl(8'h04);
    rd_pair(1'b0, "R6 mode 2 channel reached 0", 16'h0000);
  endtask

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; ctl_wr = 1'b0; dat_wr = 1'b0; dat_rd = 1'b0;
    ctl_data = '0; dat_wdata = '0; dat_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_unlatched();
    t_load_dec();
    t_wrap();
    t_oneshot();
    t_shared();
    t_latch_hold();
    t_errors();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule